// File: doc/BRIEF.md
# Dual-Port Access Collision Monitor

This block watches the access requests of both ports of a synchronous dual-port RAM. Both ports share one clock. A collision is an access by both ports to the same address in the same cycle. The block raises an active-low alert on the port or ports whose result may be wrong.

A port is flagged only when the other port writes. Two reads never alert. With one write and one read, only the reading port is flagged. With two writes, both ports are flagged.

Each alert comes a fixed two edges after the access, lasts one cycle and returns high with no action from the user. Each port's alert logic spends the cycle after an alert clearing itself. A flagged collision on that port that would land in that cycle is not reported, so an unbroken collision stream alerts on alternate cycles.

Top module: `dp_collide_mon`

## Requirements
- R1: While rst_ni is low, and after its release until the first reported collision, a_alert_no and b_alert_no are high.
- R2: A collision exists only when a_en_i and b_en_i are both 1 and a_addr_i equals b_addr_i at the same sampling edge. Any other combination produces no alert on either port.
- R3: When both ports collide with we_i = 0 (read), neither alert goes low.
- R4: When exactly one port collides with we_i = 1 (write) and the other with we_i = 0, only the reading port's alert goes low.
- R5: When both ports collide with we_i = 1, both alerts go low.
- R6: A collision sampled at rising edge N drives the flagged port's alert low right after edge N+1. The alert stays low for exactly one cycle and returns high after edge N+2 without any input.
- R7: If a port's alert went low after edge N+1, a flagged collision for that port sampled at edge N+1 is not reported. The next flagged collision after it, at edge N+2 or later, is reported normally.
- R8: With the same address on both ports every cycle and at least one port writing, each flagged port's alert is low on alternate cycles.
- R9: Suppression is kept per port: a clearing cycle on one port does not hide a flagged collision on the other port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared clock of both ports, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_en_i | input | 1 | Port A access enable |
| a_we_i | input | 1 | Port A direction: 1 write, 0 read |
| a_addr_i | input | ADDR_W | Port A address |
| b_en_i | input | 1 | Port B access enable |
| b_we_i | input | 1 | Port B direction: 1 write, 0 read |
| b_addr_i | input | ADDR_W | Port B address |
| a_alert_no | output | 1 | Port A collision alert, active low, one cycle |
| b_alert_no | output | 1 | Port B collision alert, active low, one cycle |

## Verification
The hardest situation to reach from the ports is a clearing cycle on one port colliding with a fresh flagged collision on the other port. This is the case that separates per-port suppression from shared suppression. Directed sequences cover it by swapping writer and reader on consecutive cycles at one address. Other directed sequences cover two and three back-to-back collisions and a long stream. Random traffic drawn from a four-address pool then produces dense, overlapping mixes of reads and writes, which are checked every cycle against a model built from the requirements.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  localparam int unsigned NUM_PORTS = 2;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/dpc_access_reg.sv
module dpc_access_reg
  import dpc_pkg::*;
#(
  parameter int unsigned ADDR_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output acc_kind_e         kind_o,
  output logic [ADDR_W-1:0] addr_o
);
  acc_kind_e kind_d;

  always_comb begin
    if (!en_i)     kind_d = ACC_IDLE;
    else if (we_i) kind_d = ACC_WRITE;
    else           kind_d = ACC_READ;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_o <= ACC_IDLE;
      addr_o <= '0;
    end else begin
      kind_o <= kind_d;
      addr_o <= addr_i;
    end
  end
endmodule

// File: rtl/dpc_match.sv
module dpc_match
  import dpc_pkg::*;
#(
  parameter int unsigned ADDR_W = 17
) (
  input  acc_kind_e             kind_a_i,
  input  acc_kind_e             kind_b_i,
  input  logic [ADDR_W-1:0]     addr_a_i,
  input  logic [ADDR_W-1:0]     addr_b_i,
  output logic [NUM_PORTS-1:0]  flag_o
);
  logic overlap;

  assign overlap = (kind_a_i != ACC_IDLE) && (kind_b_i != ACC_IDLE) &&
                   (addr_a_i == addr_b_i);

  // a port is at risk only when the opposite port writes
  assign flag_o[0] = overlap && (kind_b_i == ACC_WRITE);
  assign flag_o[1] = overlap && (kind_a_i == ACC_WRITE);
endmodule

// File: rtl/dpc_alert_gen.sv
module dpc_alert_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flag_i,
  output logic alert_no
);
  logic alert_q;

  // cycle after a pulse is the clearing phase: new flags are dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) alert_q <= 1'b0;
    else         alert_q <= flag_i & ~alert_q;
  end

  assign alert_no = ~alert_q;
endmodule

// File: rtl/dp_collide_mon.sv
module dp_collide_mon
  import dpc_pkg::*;
#(
  parameter int unsigned ADDR_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_en_i,
  input  logic              a_we_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic              b_en_i,
  input  logic              b_we_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  output logic              a_alert_no,
  output logic              b_alert_no
);
  logic [NUM_PORTS-1:0] en_v, we_v, flag_v, alert_nv;
  logic [ADDR_W-1:0]    addr_v   [NUM_PORTS];
  logic [ADDR_W-1:0]    addr_q_v [NUM_PORTS];
  acc_kind_e            kind_q_v [NUM_PORTS];

  assign en_v      = {b_en_i, a_en_i};
  assign we_v      = {b_we_i, a_we_i};
  assign addr_v[0] = a_addr_i;
  assign addr_v[1] = b_addr_i;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    dpc_access_reg #(.ADDR_W(ADDR_W)) u_acc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_v[p]),
      .we_i   (we_v[p]),
      .addr_i (addr_v[p]),
      .kind_o (kind_q_v[p]),
      .addr_o (addr_q_v[p])
    );

    dpc_alert_gen u_alert (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .flag_i   (flag_v[p]),
      .alert_no (alert_nv[p])
    );
  end

  dpc_match #(.ADDR_W(ADDR_W)) u_match (
    .kind_a_i (kind_q_v[0]),
    .kind_b_i (kind_q_v[1]),
    .addr_a_i (addr_q_v[0]),
    .addr_b_i (addr_q_v[1]),
    .flag_o   (flag_v)
  );

  assign a_alert_no = alert_nv[0];
  assign b_alert_no = alert_nv[1];
endmodule

// File: rtl/dpc_checker.sv
module dpc_checker #(
  parameter int unsigned ADDR_W = 17
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              a_en_i,
  input logic              a_we_i,
  input logic [ADDR_W-1:0] a_addr_i,
  input logic              b_en_i,
  input logic              b_we_i,
  input logic [ADDR_W-1:0] b_addr_i,
  input logic              a_alert_no,
  input logic              b_alert_no
);
  logic [1:0] cyc_q;
  logic       hit, hit_rr, hit_aw, hit_bw, warm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  assign warm   = (cyc_q == 2'd3);
  assign hit    = a_en_i && b_en_i && (a_addr_i == b_addr_i);
  assign hit_rr = hit && !a_we_i && !b_we_i;
  assign hit_aw = hit && a_we_i && !b_we_i;
  assign hit_bw = hit && b_we_i && !a_we_i;

  a_r1_reset_high: assert property (@(posedge clk_i) !rst_ni |-> (a_alert_no && b_alert_no));

  a_r6_a_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !a_alert_no |=> a_alert_no);
  a_r6_b_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !b_alert_no |=> b_alert_no);

  a_r2_a_needs_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && !a_alert_no) |-> $past(hit && b_we_i, 2));
  a_r2_b_needs_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && !b_alert_no) |-> $past(hit && a_we_i, 2));

  a_r3_reads_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(hit_rr, 2)) |-> (a_alert_no && b_alert_no));

  a_r4_writer_a_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(hit_aw, 2)) |-> a_alert_no);
  a_r4_writer_b_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(hit_bw, 2)) |-> b_alert_no);

  // R5 R9: a flag is reported unless that same port is in its clearing cycle
  a_r7_a_reported: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(hit && b_we_i, 2) && $past(a_alert_no)) |-> !a_alert_no);
  a_r7_b_reported: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(hit && a_we_i, 2) && $past(b_alert_no)) |-> !b_alert_no);
endmodule

bind dp_collide_mon dpc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .a_en_i     (a_en_i),
  .a_we_i     (a_we_i),
  .a_addr_i   (a_addr_i),
  .b_en_i     (b_en_i),
  .b_we_i     (b_we_i),
  .b_addr_i   (b_addr_i),
  .a_alert_no (a_alert_no),
  .b_alert_no (b_alert_no)
);

// File: tb/sim_dp_collide_mon.sv
`timescale 1ns/1ps
module sim_dp_collide_mon;
  localparam int unsigned AW = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_en = 1'b0, a_we = 1'b0, b_en = 1'b0, b_we = 1'b0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic a_alert_n, b_alert_n;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // bench model state: pending flag and last reported alert per port
  bit pa = 0, pb = 0, ra = 0, rb = 0;

  always #5 clk = ~clk;

  dp_collide_mon #(.ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .a_en_i(a_en), .a_we_i(a_we), .a_addr_i(a_addr),
    .b_en_i(b_en), .b_we_i(b_we), .b_addr_i(b_addr),
    .a_alert_no(a_alert_n), .b_alert_no(b_alert_n)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit is_flag(input bit ov, input bit other_we);
    return ov && other_we;
  endfunction

  // drive at negedge, model at posedge, compare at next negedge
  task automatic step(input logic ae, input logic aw, input logic [AW-1:0] aa,
                      input logic be, input logic bw, input logic [AW-1:0] ba,
                      input string tag);
    bit ov, ea, eb;
    a_en = ae; a_we = aw; a_addr = aa;
    b_en = be; b_we = bw; b_addr = ba;
    @(posedge clk);
    ea = pa && !ra;
    eb = pb && !rb;
    ra = ea; rb = eb;
    ov = ae && be && (aa == ba);
    pa = is_flag(ov, bw);
    pb = is_flag(ov, aw);
    @(negedge clk);
    check(tag, "a_alert_no", a_alert_n, !ra);
    check(tag, "b_alert_no", b_alert_n, !rb);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, 1'b0, 1'b0, '0, tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", "a_alert_no in reset", a_alert_n, 1'b1);
    check("R1", "b_alert_no in reset", b_alert_n, 1'b1);
    rst_n = 1'b1;
    idle(3, "R1");

    step(1, 0, 17'd5, 1, 0, 17'd5, "R3");            idle(3, "R3");
    step(1, 1, 17'd7, 1, 0, 17'd7, "R4");            idle(3, "R4");
    step(1, 0, 17'd9, 1, 1, 17'd9, "R4");            idle(3, "R4");
    step(1, 1, 17'd3, 1, 1, 17'd3, "R5");            idle(3, "R5");
    step(1, 1, 17'd3, 1, 1, 17'd4, "R2");            idle(3, "R2");
    step(0, 1, 17'd3, 1, 1, 17'd3, "R2");            idle(3, "R2");
    step(1, 1, 17'h1FFFF, 0, 1, 17'h1FFFF, "R2");    idle(3, "R2");
    step(1, 1, 17'd8, 1, 1, 17'd8, "R6");            idle(4, "R6");

    // back-to-back pair: second dropped; triple: third reported
    repeat (2) step(1, 1, 17'd11, 1, 1, 17'd11, "R7");
    idle(4, "R7");
    repeat (3) step(1, 0, 17'd12, 1, 1, 17'd12, "R7");
    idle(4, "R7");

    repeat (12) step(1, 1, 17'd20, 1, 0, 17'd20, "R8");
    idle(4, "R8");
    repeat (11) step(1, 1, 17'd21, 1, 1, 17'd21, "R8");
    idle(4, "R8");

    // writer swaps each cycle: both ports must report
    step(1, 1, 17'd2, 1, 0, 17'd2, "R9");
    step(1, 0, 17'd2, 1, 1, 17'd2, "R9");
    step(1, 1, 17'd2, 1, 0, 17'd2, "R9");
    idle(4, "R9");

    for (int i = 0; i < 3000; i++) begin
      step(1'($urandom % 4 != 0), 1'($urandom), AW'($urandom % 4),
           1'($urandom % 4 != 0), 1'($urandom), AW'($urandom % 4), "R2");
    end
    idle(4, "R6");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule